// File: doc/BRIEF.md
# Start/Stop Framed Serial Byte Transmitter

This block takes one byte at a time from a valid/ready source and drives it onto a single serial line. Each byte becomes a frame with a low start bit, eight data bits with the most significant bit first, and a high stop period. Between frames the line rests high. Timing is set by a parameter that gives the number of clocks in half a bit, so stop periods of one, one and a half or two bits are exact.

The source presents a byte with `valid_i`. The byte is taken on a clock edge where `valid_i` and `ready_o` are both high, and the start bit appears in the next cycle. `ready_o` also rises in the final cycle of the stop period, so a waiting byte follows with no extra idle. `busy_o` shows that a frame is on the line.

Top module: `async_frame_tx`

## Requirements
- R1: When no frame is in progress, `line_o` is 1, `busy_o` is 0 and `ready_o` is 1.
- R2: A byte is taken on a rising edge where `valid_i` and `ready_o` are both 1; from the next cycle `line_o` is 0 (start bit) for 2*HALF_BIT_CLKS clocks.
- R3: After the start bit, `line_o` carries data bits 7 down to 0 in that order, each held for 2*HALF_BIT_CLKS clocks.
- R4: After bit 0, `line_o` is 1 for a stop period set by `stop_sel_i`: 2'b00 gives 2, 2'b01 gives 3, and 2'b10 or 2'b11 give 4 half-bit units of HALF_BIT_CLKS clocks.
- R5: `stop_sel_i` is sampled on the edge that takes the byte; later changes do not affect the frame in progress.
- R6: `ready_o` is 1 in the last cycle of the stop period; a byte taken on that edge starts its start bit in the next cycle. Byte 0x41 gives the per-bit sequence 0,0,1,0,0,0,0,0,1,1 with a one-bit stop period.
- R7: `ready_o` is 0 from the cycle after acceptance until the last stop cycle. A byte offered in that time is not taken, and changing `data_i` does not alter the frame in progress.
- R8: `busy_o` is 1 from the cycle after acceptance through the last cycle of the stop period.
- R9: Asserting `rst_ni` low at any time, even during a frame, drops the frame at once and forces the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_sel_i | input | 2 | Stop period select (00: 1 bit, 01: 1.5 bits, 1x: 2 bits) |
| data_i | input | DATA_BITS | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Byte can be taken on this edge |
| line_o | output | 1 | Serial line, idles high |
| busy_o | output | 1 | Frame in progress |

## Verification
The start bit is due in the first cycle after the accepting edge. Cycle i of the frame, counted from 0, lies in half-bit unit i/HALF_BIT_CLKS, and that unit sets the expected line level. `ready_o` is expected high only in cycle (18+S)*HALF_BIT_CLKS-1, where S is the number of stop half-bits. The bench samples every output at the falling edge of each cycle of every frame, over all 256 byte values for each of the four stop codes, with frames both back-to-back and separated by idle.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_DATA, PH_STOP} tx_phase_e;

  // stop period length in half-bit units
  function automatic logic [2:0] stop_halves(input logic [1:0] sel);
    case (sel)
      2'b00:   return 3'd2;
      2'b01:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/tx_half_tick.sv
module tx_half_tick #(
  parameter int unsigned HALF_BIT_CLKS = 217
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_BIT_CLKS > 1) ? $clog2(HALF_BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_BIT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (en_i)    cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 shift_i,
  output logic                 msb_o
);
  logic [DATA_BITS-1:0] sh_q;

  assign msb_o = sh_q[DATA_BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '1;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {sh_q[DATA_BITS-2:0], 1'b1};
  end
endmodule

// File: rtl/tx_seq.sv
module tx_seq
  import tx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       tick_i,
  input  logic [1:0] stop_sel_i,
  output tx_phase_e  phase_o,
  output logic       shift_o,
  output logic       last_o
);
  localparam int unsigned HCW = $clog2(2 * DATA_BITS + 4);
  localparam logic [HCW-1:0] LAST_DATA = HCW'(2 * DATA_BITS - 1);

  tx_phase_e      phase_q;
  logic [HCW-1:0] hc_q;
  logic [2:0]     stop_h_q;

  assign phase_o = phase_q;
  assign shift_o = (phase_q == PH_DATA) && tick_i && hc_q[0];
  assign last_o  = (phase_q == PH_STOP) && tick_i && (hc_q == HCW'(stop_h_q - 3'd1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      hc_q     <= '0;
      stop_h_q <= 3'd2;
    end else if (accept_i) begin
      phase_q  <= PH_START;
      hc_q     <= '0;
      stop_h_q <= stop_halves(stop_sel_i);
    end else if (tick_i) begin
      case (phase_q)
        PH_START: begin
          if (hc_q == HCW'(1)) begin
            phase_q <= PH_DATA;
            hc_q    <= '0;
          end else hc_q <= hc_q + 1'b1;
        end
        PH_DATA: begin
          if (hc_q == LAST_DATA) begin
            phase_q <= PH_STOP;
            hc_q    <= '0;
          end else hc_q <= hc_q + 1'b1;
        end
        PH_STOP: begin
          if (last_o) begin
            phase_q <= PH_IDLE;
            hc_q    <= '0;
          end else hc_q <= hc_q + 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import tx_pkg::*;
#(
  parameter int unsigned HALF_BIT_CLKS = 217,
  parameter int unsigned DATA_BITS     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           stop_sel_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  output logic                 line_o,
  output logic                 busy_o
);
  tx_phase_e phase;
  logic      tick, shift, last, msb, accept;

  assign busy_o  = (phase != PH_IDLE);
  assign ready_o = !busy_o || last;
  assign accept  = valid_i && ready_o;

  always_comb begin
    case (phase)
      PH_START: line_o = 1'b0;
      PH_DATA:  line_o = msb;
      default:  line_o = 1'b1;
    endcase
  end

  tx_half_tick #(.HALF_BIT_CLKS(HALF_BIT_CLKS)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(accept),
    .en_i   (busy_o),
    .tick_o (tick)
  );

  tx_seq #(.DATA_BITS(DATA_BITS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .tick_i    (tick),
    .stop_sel_i(stop_sel_i),
    .phase_o   (phase),
    .shift_o   (shift),
    .last_o    (last)
  );

  tx_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .data_i (data_i),
    .shift_i(shift),
    .msb_o  (msb)
  );
endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk #(
  parameter int unsigned HALF_BIT_CLKS = 217,
  parameter int unsigned DATA_BITS     = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic line_o,
  input logic busy_o
);
  localparam int unsigned MIN_LEN = (2 * DATA_BITS + 4) * HALF_BIT_CLKS;
  localparam int unsigned MAX_LEN = (2 * DATA_BITS + 6) * HALF_BIT_CLKS;

  // cycles since the first cycle of the current frame
  logic [31:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    since_q <= '0;
    else if (valid_i && ready_o)    since_q <= '0;
    else if (since_q != '1)         since_q <= since_q + 1'b1;
  end

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (line_o && ready_o));

  p_start_bit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> (!line_o && busy_o));

  p_bit_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && (line_o != $past(line_o))) |-> ((since_q % HALF_BIT_CLKS) == 0));

  p_frame_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ready_o) |-> (line_o && (((since_q + 1) % HALF_BIT_CLKS) == 0)
                             && (since_q + 1 >= MIN_LEN) && (since_q + 1 <= MAX_LEN)));

  p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ready_o) |=> busy_o);
endmodule

bind async_frame_tx async_frame_tx_chk #(
  .HALF_BIT_CLKS(HALF_BIT_CLKS),
  .DATA_BITS    (DATA_BITS)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .ready_o(ready_o),
  .line_o (line_o),
  .busy_o (busy_o)
);

// File: tb/sim_async_frame_tx.sv
module sim_async_frame_tx;
  localparam int HB = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] sel = '0;
  logic       ready, line, busy;
  int         vectors = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  async_frame_tx #(.HALF_BIT_CLKS(HB), .DATA_BITS(8)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .stop_sel_i(sel), .data_i(data),
    .valid_i(valid), .ready_o(ready), .line_o(line), .busy_o(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int halves(input int s);
    return (s == 0) ? 2 : (s == 1) ? 3 : 4;
  endfunction

  // entered at a falling edge with valid high and the byte on data
  task automatic frame(input logic [7:0] d, input int s, input bit nb2b,
                       input logic [7:0] nd, input int ns);
    int len;
    len = (18 + halves(s)) * HB;
    check("R7 ready before accept", int'(ready), 1);
    @(posedge clk); @(negedge clk);
    for (int i = 0; i < len; i++) begin
      int h;
      int e;
      if (i > 0) begin @(posedge clk); @(negedge clk); end
      if (i == 0) begin
        sel = 2'(s ^ 1);            // R5: change mid-frame
        if (nb2b) begin data = nd; valid = 1'b1; end  // R7: offered early
        else valid = 1'b0;
      end
      h = i / HB;
      if (h < 2) begin
        check("R2 start bit", int'(line), 0);
      end else if (h < 18) begin
        e = int'(d[7 - (h - 2) / 2]);
        check("R3 data bit", int'(line), e);
      end else begin
        check("R4 R5 stop level", int'(line), 1);
      end
      check("R8 busy", int'(busy), 1);
      check("R6 R7 ready timing", int'(ready), (i == len - 1) ? 1 : 0);
      if (i == len - 1) sel = 2'(ns);
    end
    if (!nb2b) begin
      repeat (3) begin
        @(posedge clk); @(negedge clk);
        check("R1 idle line", int'(line), 1);
        check("R1 idle busy", int'(busy), 0);
        check("R1 idle ready", int'(ready), 1);
      end
      data  = nd;
      valid = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset line", int'(line), 1);
    check("R9 reset busy", int'(busy), 0);
    check("R9 reset ready", int'(ready), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", int'(line), 1);

    data = 8'h00; sel = 2'b00; valid = 1'b1;
    for (int k = 0; k < 1024; k++) begin
      bit nb;
      nb = (k % 5 != 4) && (k < 1023);
      frame(8'(k), k / 256, nb, 8'(k + 1), ((k + 1) / 256) % 4);
    end

    // R9: reset in the middle of a frame
    data = 8'hA5; sel = 2'b10; valid = 1'b1;
    @(posedge clk); @(negedge clk);
    valid = 1'b0;
    repeat (7) begin @(posedge clk); @(negedge clk); end
    check("R8 busy mid-frame", int'(busy), 1);
    rst_ni = 1'b0;
    #1;
    check("R9 abort line", int'(line), 1);
    check("R9 abort busy", int'(busy), 0);
    check("R9 abort ready", int'(ready), 1);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R9 idle after abort", int'(line), 1);
      check("R9 busy after abort", int'(busy), 0);
    end

    // R6: byte 0x41 with one stop bit
    data = 8'h41; sel = 2'b00; valid = 1'b1;
    frame(8'h41, 0, 1'b0, 8'h00, 0);
    valid = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule